// File: doc/BRIEF.md
# ADC Port Sweep Sequencer

The sequencer decides which of a row of mixed-signal ports the single shared ADC converts next, and when. Each port carries a 16-bit configuration word. A port takes part in conversions only when its mode nibble names one of the ADC input modes. A two-bit run code chooses one of four behaviours: stay quiet, convert every ADC port once per strobe, convert one port per strobe, or cycle through the ADC ports without end.

For each port it visits, the block asks the converter stand-in for 2^n samples over a request/acknowledge handshake. It adds them into a wide accumulator and then writes the mean to that port's result slot in one strobed write. The exponent n comes from the port's own configuration word. A busy flag covers the span from the trigger to the last result write of the run.

The controller has three states:

- ST_IDLE waits for a trigger.
- ST_SAMPLE holds a request open and collects samples.
- ST_WRITE commits one result.

It has five transitions:

- launch: ST_IDLE to ST_SAMPLE.
- finish-port: ST_SAMPLE to ST_WRITE, on the final acknowledged sample.
- advance: ST_WRITE to ST_SAMPLE, when the next port is loaded in the write cycle.
- stop: ST_WRITE to ST_IDLE.
- hold: every state stays put otherwise.

Top module: `adc_sweep_seq`

## Requirements
- R1: After reset, and whenever the run code is 0, no request, no result write and no busy appear. A strobe under code 0 starts nothing.
- R2: A port is ADC-configured when configuration bits 15:12 hold 7, 8 or 9. No other port is ever requested or written.
- R3: Under code 1, a strobe converts each ADC-configured port once, in rising index order, and then the block returns to idle.
- R4: Under code 2, each strobe converts one port. The first is the lowest ADC-configured index, and each later strobe moves to the next higher one. After the highest, the next strobe wraps to the lowest. While the code is not 2, the position returns to the lowest port.
- R5: Under code 3, ADC-configured ports are converted in rising order with wrap-around, with no strobe needed. Strobes have no effect. Leaving code 3 ends the run at the next result write.
- R6: Configuration bits 7:5 hold n. The port takes 2^n acknowledged samples (1 to 128), and its 12-bit result is the 19-bit sum shifted right by n. The result is written the cycle after the last sample.
- R7: The request stays high with a stable channel index until it is acknowledged. Each acknowledged cycle consumes one sample.
- R8: Busy rises the cycle after the trigger and falls the cycle after the last result write of the run.
- R9: With no ADC-configured port, strobes and code 3 start nothing, and busy stays low.
- R10: A strobe that arrives while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_mode | input | 2 | Run code: 0 quiet, 1 one sweep, 2 one port, 3 endless |
| cnv_start | input | 1 | Conversion strobe, one cycle |
| port_cfg | input | NPORT*16 | Configuration words, port k in bits 16k+15:16k |
| adc_req | output | 1 | Sample request to the converter |
| adc_chan | output | 5 | Port index being sampled |
| adc_ack | input | 1 | Converter accepts the request; sample valid |
| adc_sample | input | 12 | Sample value, valid with adc_ack |
| res_we | output | 1 | Result write strobe |
| res_idx | output | 5 | Port index of the result |
| res_data | output | 12 | Averaged result |
| busy | output | 1 | A sweep or conversion is in progress |

## Verification
Two things can happen in the same cycle: committing one port's mean, and loading the next port while its accumulator is cleared. Both occur in ST_WRITE whenever a sweep or endless run continues.

The bench provokes this with adjacent single-sample ports and with acknowledge patterns that vary from cycle to cycle. A late strobe is also dropped into the middle of a sweep. A behavioural model in the bench tracks the expected phase, port, sample count and running sum. Every clock, it judges the written value against that model, along with the start of the next port's requests.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int CFG_W   = 16;
    localparam int MODE_LO = 12;
    localparam int MODE_W  = 4;
    localparam int NLOG_LO = 5;
    localparam int NLOG_W  = 3;

    typedef enum logic [1:0] {
        RUN_QUIET  = 2'd0,
        RUN_SWEEP  = 2'd1,
        RUN_SINGLE = 2'd2,
        RUN_LOOP   = 2'd3
    } run_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_WRITE  = 2'd2
    } st_e;

    function automatic logic is_adc_mode(input logic [MODE_W-1:0] m);
        return (m == 4'd7) || (m == 4'd8) || (m == 4'd9);
    endfunction

endpackage

// File: rtl/port_scan.sv
module port_scan #(
    parameter int NPORT = 20,
    parameter int IDXW  = 5
) (
    input  logic [NPORT-1:0] mask,
    input  logic [IDXW:0]    start,
    output logic             hit_up,
    output logic [IDXW-1:0]  idx_up,
    output logic             hit_any,
    output logic [IDXW-1:0]  idx_any
);
    // descending walk so the lowest qualifying index wins
    always_comb begin
        hit_up  = 1'b0;
        idx_up  = '0;
        hit_any = 1'b0;
        idx_any = '0;
        for (int i = NPORT - 1; i >= 0; i--) begin
            if (mask[i]) begin
                hit_any = 1'b1;
                idx_any = IDXW'(i);
                if ((IDXW+1)'(i) >= start) begin
                    hit_up = 1'b1;
                    idx_up = IDXW'(i);
                end
            end
        end
    end
endmodule

// File: rtl/sample_avg.sv
module sample_avg #(
    parameter int SW     = 12,
    parameter int MAXLOG = 7,
    parameter int NLW    = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           add,
    input  logic [SW-1:0]  sample,
    input  logic [NLW-1:0] nlog,
    output logic           last,
    output logic [SW-1:0]  mean
);
    localparam int SUMW = SW + MAXLOG;

    logic [SUMW-1:0]   acc;
    logic [MAXLOG-1:0] cnt;
    logic [MAXLOG:0]   lim;

    assign lim  = ((MAXLOG+1)'(1) << nlog) - (MAXLOG+1)'(1);
    assign last = (cnt == lim[MAXLOG-1:0]);
    assign mean = SW'(acc >> nlog);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
            cnt <= '0;
        end else if (clr) begin
            acc <= '0;
            cnt <= '0;
        end else if (add) begin
            acc <= acc + SUMW'(sample);
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/adc_sweep_seq.sv
module adc_sweep_seq
    import adc_seq_pkg::*;
#(
    parameter int NPORT  = 20,
    parameter int SW     = 12,
    parameter int MAXLOG = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             ctl_mode,
    input  logic                   cnv_start,
    input  logic [NPORT*CFG_W-1:0] port_cfg,
    output logic                   adc_req,
    output logic [$clog2(NPORT)-1:0] adc_chan,
    input  logic                   adc_ack,
    input  logic [SW-1:0]          adc_sample,
    output logic                   res_we,
    output logic [$clog2(NPORT)-1:0] res_idx,
    output logic [SW-1:0]          res_data,
    output logic                   busy
);
    localparam int IDXW = $clog2(NPORT);

    st_e                state, nxt;
    run_e               ctl, run_q;
    logic [IDXW-1:0]    cur_q, sc_ptr, load_idx;
    logic [NLOG_W-1:0]  nlog_q;
    logic               load, trig;
    logic [NPORT-1:0]   adc_mask;
    logic [IDXW:0]      scan_from;
    logic               hit_up, hit_any, last;
    logic [IDXW-1:0]    idx_up, idx_any;
    logic [SW-1:0]      mean;

    assign ctl = run_e'(ctl_mode);

    for (genvar g = 0; g < NPORT; g++) begin : g_mask
        assign adc_mask[g] = is_adc_mode(port_cfg[g*CFG_W + MODE_LO +: MODE_W]);
    end

    always_comb begin
        if (state == ST_WRITE)
            scan_from = {1'b0, cur_q} + 1'b1;
        else if (ctl == RUN_SINGLE)
            scan_from = {1'b0, sc_ptr};
        else
            scan_from = '0;
    end

    port_scan #(.NPORT(NPORT), .IDXW(IDXW)) u_scan (
        .mask    (adc_mask),
        .start   (scan_from),
        .hit_up  (hit_up),
        .idx_up  (idx_up),
        .hit_any (hit_any),
        .idx_any (idx_any)
    );

    sample_avg #(.SW(SW), .MAXLOG(MAXLOG), .NLW(NLOG_W)) u_avg (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (load),
        .add    (state == ST_SAMPLE && adc_ack),
        .sample (adc_sample),
        .nlog   (nlog_q),
        .last   (last),
        .mean   (mean)
    );

    assign trig = (ctl == RUN_LOOP) ||
                  (cnv_start && (ctl == RUN_SWEEP || ctl == RUN_SINGLE));

    // next state and port load decision
    always_comb begin
        nxt      = state;
        load     = 1'b0;
        load_idx = hit_up ? idx_up : idx_any;
        unique case (state)
            ST_IDLE: begin
                if (trig && hit_any) begin
                    nxt  = ST_SAMPLE;
                    load = 1'b1;
                end
            end
            ST_SAMPLE: begin
                if (adc_ack && last)
                    nxt = ST_WRITE;
            end
            ST_WRITE: begin
                nxt = ST_IDLE;
                if (run_q == RUN_SWEEP && hit_up) begin
                    nxt  = ST_SAMPLE;
                    load = 1'b1;
                end else if (run_q == RUN_LOOP && ctl == RUN_LOOP && hit_any) begin
                    nxt  = ST_SAMPLE;
                    load = 1'b1;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cur_q  <= '0;
            nlog_q <= '0;
            run_q  <= RUN_QUIET;
            sc_ptr <= '0;
        end else begin
            state <= nxt;
            if (load) begin
                cur_q  <= load_idx;
                nlog_q <= port_cfg[load_idx*CFG_W + NLOG_LO +: NLOG_W];
            end
            if (state == ST_IDLE && load)
                run_q <= ctl;
            if (ctl != RUN_SINGLE)
                sc_ptr <= '0;
            else if (state == ST_WRITE && run_q == RUN_SINGLE)
                sc_ptr <= (cur_q == IDXW'(NPORT - 1)) ? '0 : cur_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        busy     = (state != ST_IDLE);
        adc_req  = (state == ST_SAMPLE);
        adc_chan = cur_q;
        res_we   = (state == ST_WRITE);
        res_idx  = cur_q;
        res_data = mean;
    end
endmodule

// File: rtl/adc_sweep_seq_chk.sv
module adc_sweep_seq_chk
    import adc_seq_pkg::*;
#(
    parameter int NPORT = 20
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [1:0]               ctl_mode,
    input logic [NPORT*CFG_W-1:0]   port_cfg,
    input logic                     adc_req,
    input logic [$clog2(NPORT)-1:0] adc_chan,
    input logic                     adc_ack,
    input logic                     res_we,
    input logic [$clog2(NPORT)-1:0] res_idx,
    input logic                     busy
);
    logic any_adc;
    always_comb begin
        any_adc = 1'b0;
        for (int i = 0; i < NPORT; i++)
            if (is_adc_mode(port_cfg[i*CFG_W + MODE_LO +: MODE_W]))
                any_adc = 1'b1;
    end

    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && ctl_mode == 2'd0) |=> !busy);

    assert_write_cfg_R2: assert property (@(posedge clk) disable iff (!rst_n)
        res_we |-> is_adc_mode(port_cfg[res_idx*CFG_W + MODE_LO +: MODE_W]));

    assert_write_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
        res_we |-> ($past(adc_req) && $past(adc_ack) && $past(adc_chan) == res_idx));

    assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_req && !adc_ack) |=> (adc_req && $stable(adc_chan)));

    assert_busy_cover_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_we || adc_req) |-> busy);

    assert_no_ports_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !any_adc) |=> !busy);
endmodule

bind adc_sweep_seq adc_sweep_seq_chk #(.NPORT(NPORT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_mode (ctl_mode),
    .port_cfg (port_cfg),
    .adc_req  (adc_req),
    .adc_chan (adc_chan),
    .adc_ack  (adc_ack),
    .res_we   (res_we),
    .res_idx  (res_idx),
    .busy     (busy)
);

// File: tb/adc_sweep_seq_bench.sv
`timescale 1ns/1ps
module adc_sweep_seq_bench;
    localparam int NPORT = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        ctl_mode = 2'd0;
    logic              cnv_start = 1'b0;
    logic [15:0]       cfg_w [NPORT];
    logic [NPORT*16-1:0] port_cfg;
    logic              adc_req, adc_ack = 1'b0, res_we, busy;
    logic [4:0]        adc_chan, res_idx;
    logic [11:0]       adc_sample = '0, res_data;

    always #10 clk = ~clk;

    always_comb
        for (int i = 0; i < NPORT; i++) port_cfg[i*16 +: 16] = cfg_w[i];

    adc_sweep_seq u_adc_sweep_seq (
        .clk(clk), .rst_n(rst_n), .ctl_mode(ctl_mode), .cnv_start(cnv_start),
        .port_cfg(port_cfg), .adc_req(adc_req), .adc_chan(adc_chan),
        .adc_ack(adc_ack), .adc_sample(adc_sample), .res_we(res_we),
        .res_idx(res_idx), .res_data(res_data), .busy(busy)
    );

    int total = 0, bad = 0;
    bit done = 0;
    string tag = "R1";
    int wlog[$];
    int hs = 0;
    int unsigned rng = 32'h1234_5678;
    int ack_mode = 0;   // 0 random, 1 always

    task automatic chk(bit ok, string t, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", t, what, act, exp);
        end
    endtask

    // converter stand-in
    always @(posedge clk) begin
        #2;
        rng = rng * 1103515245 + 12345;
        adc_ack <= (ack_mode == 1) ? 1'b1 : rng[16];
        adc_sample <= 12'((hs * 613 + 97) % 4096);
    end

    // behavioural reference
    int m_ph = 0, m_cur = 0, m_n = 0, m_cnt = 0, m_sum = 0, m_run = 0, m_scp = 0;

    function automatic bit isadc(int p);
        int m = int'(cfg_w[p][15:12]);
        return m >= 7 && m <= 9;
    endfunction

    function automatic int first_from(int s);
        for (int i = s; i < NPORT; i++) if (isadc(i)) return i;
        return -1;
    endfunction

    task automatic m_start(int p);
        m_ph = 1; m_cur = p; m_n = int'(cfg_w[p][7:5]); m_cnt = 0; m_sum = 0;
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_scp = 0; m_run = 0;
        end else begin
            int ctl, nscp, p;
            chk(busy == (m_ph != 0), tag, "busy", busy, m_ph != 0);
            chk(adc_req == (m_ph == 1), tag, "adc_req", adc_req, m_ph == 1);
            if (m_ph == 1) chk(adc_chan == m_cur, tag, "adc_chan", adc_chan, m_cur);
            chk(res_we == (m_ph == 2), tag, "res_we", res_we, m_ph == 2);
            if (m_ph == 2) begin
                chk(res_idx == m_cur, tag, "res_idx", res_idx, m_cur);
                chk(res_data == 12'(m_sum >> m_n), tag, "res_data R6", res_data, m_sum >> m_n);
            end
            if (res_we) wlog.push_back(int'(res_idx));
            ctl = int'(ctl_mode);
            nscp = m_scp;
            if (ctl != 2) nscp = 0;
            else if (m_ph == 2 && m_run == 2) nscp = (m_cur == NPORT - 1) ? 0 : m_cur + 1;
            case (m_ph)
                0: if (ctl == 3 || (cnv_start && (ctl == 1 || ctl == 2))) begin
                       p = first_from(ctl == 2 ? m_scp : 0);
                       if (p < 0) p = first_from(0);
                       if (p >= 0) begin m_start(p); m_run = ctl; end
                   end
                1: if (adc_ack) begin
                       m_sum += int'(adc_sample);
                       m_cnt++;
                       if (m_cnt == (1 << m_n)) m_ph = 2;
                   end
                default: begin
                    m_ph = 0;
                    if (m_run == 1) begin
                        p = first_from(m_cur + 1);
                        if (p >= 0) m_start(p);
                    end else if (m_run == 3 && ctl == 3) begin
                        p = first_from(m_cur + 1);
                        if (p < 0) p = first_from(0);
                        if (p >= 0) m_start(p);
                    end
                end
            endcase
            m_scp = nscp;
            if (adc_req && adc_ack) hs++;
        end
    end

    task automatic strobe();
        @(posedge clk); #2 cnv_start = 1'b1;
        @(posedge clk); #2 cnv_start = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog run did not complete actual=0 expected=1");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NPORT; i++) cfg_w[i] = 16'h0000;
        // port 0 mode 6 and port 5 mode 5: not ADC inputs (R2)
        cfg_w[0]  = 16'h6000;
        cfg_w[5]  = 16'h5000;
        cfg_w[2]  = 16'h7000;                 // n=0
        cfg_w[3]  = 16'h9000;                 // n=0
        cfg_w[7]  = 16'h8000 | (16'd2 << 5);  // n=2
        cfg_w[19] = 16'h9000 | (16'd1 << 5);  // n=1
        repeat (3) @(posedge clk);
        #1;
        chk(busy == 0 && adc_req == 0 && res_we == 0, "R1", "reset outputs", busy, 0);
        #1 rst_n = 1'b1;

        tag = "R1";
        strobe();
        repeat (20) @(negedge clk);
        chk(wlog.size() == 0 && busy == 0, "R1", "writes under code 0", wlog.size(), 0);

        tag = "R3";
        ctl_mode = 2'd1;
        strobe();
        repeat (4) @(posedge clk);
        tag = "R10";
        strobe();          // arrives while busy
        wait_idle();
        tag = "R3";
        chk(wlog.size() == 4, "R3", "sweep write count", wlog.size(), 4);
        if (wlog.size() == 4) begin
            chk(wlog[0] == 2, "R2", "sweep first port", wlog[0], 2);
            chk(wlog[1] == 3, "R3", "sweep second port", wlog[1], 3);
            chk(wlog[2] == 7, "R2", "sweep third port", wlog[2], 7);
            chk(wlog[3] == 19, "R3", "sweep last port", wlog[3], 19);
        end
        wlog.delete();

        // back-to-back commit/load with a constant acknowledge
        ack_mode = 1;
        tag = "R6";
        strobe();
        wait_idle();
        chk(wlog.size() == 4, "R6", "constant-ack sweep count", wlog.size(), 4);
        wlog.delete();
        ack_mode = 0;

        tag = "R4";
        ctl_mode = 2'd2;
        for (int k = 0; k < 5; k++) begin
            strobe();
            wait_idle();
        end
        chk(wlog.size() == 5, "R4", "single conversions", wlog.size(), 5);
        if (wlog.size() == 5) begin
            chk(wlog[0] == 2 && wlog[1] == 3 && wlog[2] == 7, "R4", "advance order", wlog[2], 7);
            chk(wlog[3] == 19, "R4", "highest port", wlog[3], 19);
            chk(wlog[4] == 2, "R4", "wrap to lowest", wlog[4], 2);
        end
        wlog.delete();
        ctl_mode = 2'd0;
        repeat (2) @(posedge clk);
        #2 ctl_mode = 2'd2;
        strobe();
        wait_idle();
        chk(wlog.size() == 1 && wlog[0] == 2, "R4", "position reset off code 2",
            wlog.size() > 0 ? wlog[0] : -1, 2);
        wlog.delete();

        tag = "R6";
        for (int i = 0; i < NPORT; i++) cfg_w[i] = 16'h0000;
        cfg_w[11] = 16'h7000 | (16'd7 << 5);  // 128 samples
        ctl_mode = 2'd1;
        strobe();
        wait_idle();
        chk(wlog.size() == 1 && wlog[0] == 11, "R6", "128-sample result written once", wlog.size(), 1);
        wlog.delete();

        tag = "R5";
        cfg_w[11] = 16'h8000;
        cfg_w[4]  = 16'h9000 | (16'd1 << 5);
        ctl_mode = 2'd3;
        repeat (60) @(posedge clk);
        strobe();
        repeat (200) @(posedge clk);
        #2 ctl_mode = 2'd0;
        wait_idle();
        chk(wlog.size() > 10, "R5", "endless run writes", wlog.size(), 11);
        if (wlog.size() > 2)
            chk(wlog[0] == 4 && wlog[1] == 11 && wlog[2] == 4, "R5", "endless order with wrap", wlog[2], 4);
        chk(busy == 0, "R5", "stops after leaving code 3", busy, 0);
        wlog.delete();

        tag = "R9";
        for (int i = 0; i < NPORT; i++) cfg_w[i] = 16'h5000;
        ctl_mode = 2'd1;
        strobe();
        #2 ctl_mode = 2'd3;
        repeat (30) @(negedge clk);
        chk(busy == 0 && wlog.size() == 0, "R9", "no ADC ports stays idle", busy, 0);

        finish_run();
    end
endmodule